// File: doc/BRIEF.md
# Multi-channel compare-match timer

The block is a memory-mapped timer with several identical channels. Each channel owns a configuration word, an up-counter and a compare register. A slow reference tick enters the block as a one-cycle enable pulse. A per-channel prescaler turns that pulse into a count tick, dividing by 1, 8, 32 or 128. A single global run word holds one bit per channel, and each channel counts only while its own bit is set.

When a count tick finds the counter equal to the compare value, the channel sets a sticky match flag. In clear mode the counter then restarts from zero, which gives periodic operation with a period of compare+1 ticks. In free mode it keeps counting and sets a sticky overflow flag when it wraps from all-ones to zero. Software clears a flag by writing 0 to it; writing 1 leaves it alone. Each channel drives an interrupt level and a one-cycle DMA request pulse, and a request-type field chooses between them.

Writes to the configuration and compare registers are held back for a fixed number of clocks before they apply. A counter write is held back longer, and a pending bit reads 1 until the new value is loaded. Each of these delayed writes runs in a small two-state machine. DW_IDLE moves to DW_WAIT on a bus write and loads its countdown. DW_WAIT counts down, and on the cycle its countdown reads zero it issues a one-cycle load and returns to DW_IDLE. A new write in DW_WAIT restarts the countdown with the newer data.

Top module: `cmt_timer`

## Requirements
- R1: After reset every configuration word reads 0, every counter reads 0, every compare register reads all-ones, the run word reads 0, and all irq and dreq outputs are 0.
- R2: The run word sits at byte address 0x000. Bit i starts (1) or stops (0) channel i only, from the clock edge that samples the write. A stopped channel's counter holds its value.
- R3: Configuration bits 2:0 select the count tick from ref_tick pulses: code 7 counts every pulse, code 4 every 8th, code 5 every 32nd and code 6 every 128th. Codes 0 to 3 never count. The prescaler restarts while the channel is stopped.
- R4: A counter write loads the new value 3 clocks after the edge that samples it. Configuration bit 13 reads 1 from that edge until the load, and the counter keeps its old behaviour meanwhile.
- R5: Configuration fields and compare writes take effect, in readback and in behaviour, 2 clocks after the edge that samples the write.
- R6: A count tick with counter equal to compare sets the sticky match flag at configuration bit 15.
- R7: With configuration bit 8 set, the tick that finds counter equal to compare loads 0 instead of incrementing, so the period is compare+1 ticks.
- R8: In free mode, a tick at counter all-ones wraps it to 0 and sets the sticky overflow flag at configuration bit 14.
- R9: A configuration write with bit 15 or bit 14 at 0 clears that flag at the sampling edge, and a 1 leaves it unchanged. A flag set in the same cycle as its clear stays set.
- R10: irq[i] is 1 exactly while channel i's match flag is set, its request field (bits 5:4) equals 2, and its output-enable bit 7 is 1.
- R11: With request field 1, dreq[i] is a one-clock pulse in the cycle after each matching tick, and irq[i] stays 0.
- R12: Channel i occupies byte address 0x10 + 0x10*i, with configuration, counter and compare at offsets 0, 4 and 8. Unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulses of the slow reference clock |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1 together with bus_sel |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NCH | Per-channel interrupt level |
| dreq | output | NCH | Per-channel DMA request pulse |

## Verification
Two events can meet in one cycle: a software write that clears the match flag, and a count tick that sets the same flag. The bench counts clock edges from the start write of a channel with period 5. It then places a flag-clearing write exactly on a later match edge, and a second one on an edge that is not a match. The flag must still read 1 after the coincident write and must read 0 after the other one. A randomized ref_tick stream also drives a divide-by-1 and a divide-by-8 channel side by side, and their counters are compared with the pulse count at random points.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [0:0] {
        DW_IDLE,
        DW_WAIT
    } dw_state_e;

    localparam int FLAG_MATCH_BIT = 15;
    localparam int FLAG_OVF_BIT   = 14;

    localparam logic [1:0] REQ_NONE = 2'd0;
    localparam logic [1:0] REQ_DMA  = 2'd1;
    localparam logic [1:0] REQ_IRQ  = 2'd2;

    // applied configuration fields of a channel
    typedef struct packed {
        logic       clr_mode;   // word bit 8
        logic       out_en;     // word bit 7
        logic [1:0] req_sel;    // word bits 5:4
        logic [2:0] cks;        // word bits 2:0
    } chan_cfg_t;

    // prescale ratio for a clock-select code, 0 means no counting
    function automatic logic [7:0] cks_divisor(input logic [2:0] cks);
        logic [7:0] d;
        case (cks)
            3'd4:    d = 8'd8;
            3'd5:    d = 8'd32;
            3'd6:    d = 8'd128;
            3'd7:    d = 8'd1;
            default: d = 8'd0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cmt_delay_write.sv
module cmt_delay_write #(
    parameter int W   = 32,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         busy,
    output logic         load,
    output logic [W-1:0] ldata
);
    import cmt_pkg::*;

    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    dw_state_e     state_q;
    logic [CW-1:0] left_q;
    logic [W-1:0]  data_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DW_IDLE;
            left_q  <= '0;
            data_q  <= '0;
        end else if (wr) begin
            state_q <= DW_WAIT;
            left_q  <= CW'(LAT - 1);
            data_q  <= wdata;
        end else begin
            unique case (state_q)
                DW_IDLE: state_q <= DW_IDLE;
                DW_WAIT: begin
                    if (left_q == '0) state_q <= DW_IDLE;
                    else              left_q  <= left_q - 1'b1;
                end
                default: state_q <= DW_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy  = 1'b0;
        load  = 1'b0;
        ldata = data_q;
        unique case (state_q)
            DW_IDLE: ;
            DW_WAIT: begin
                busy = 1'b1;
                load = (left_q == '0);
            end
            default: ;
        endcase
    end

    // R4 / R5: a write always leaves the unit waiting on the next cycle
    a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> busy);

endmodule

// File: rtl/cmt_prescaler.sv
module cmt_prescaler (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       ref_tick,
    input  logic [2:0] cks,
    output logic       tick
);
    import cmt_pkg::*;

    logic [7:0] div;
    logic [7:0] pc_q;
    logic       at_end;

    always_comb begin
        div    = cks_divisor(cks);
        at_end = (div != 8'd0) && (pc_q >= div - 8'd1);
        tick   = run && ref_tick && at_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (!run || div == 8'd0) begin
            pc_q <= '0;
        end else if (ref_tick) begin
            if (at_end) pc_q <= '0;
            else        pc_q <= pc_q + 8'd1;
        end
    end

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
    parameter int CNT_W   = 32,
    parameter int CFG_LAT = 2,
    parameter int CNT_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             run,
    input  logic             wr_ctl,
    input  logic             wr_cnt,
    input  logic             wr_cmp,
    input  logic [31:0]      wdata,
    output logic [31:0]      ctl_rd,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             irq,
    output logic             dreq
);
    import cmt_pkg::*;

    chan_cfg_t        cfg_q;
    chan_cfg_t        cfg_ld;
    logic [6:0]       cfg_ldata;
    logic             cfg_load;
    logic             cfg_busy;
    logic             cnt_ld;
    logic             cnt_busy;
    logic [CNT_W-1:0] cnt_ldata;
    logic             cmp_ld;
    logic             cmp_busy;
    logic [CNT_W-1:0] cmp_ldata;
    logic             tick;
    logic             match_ev;
    logic             wrap_ev;
    logic             mflag_q;
    logic             ovf_q;
    logic             dreq_q;

    cmt_delay_write #(.W(7), .LAT(CFG_LAT)) u_dw_cfg (
        .clk(clk), .rst_n(rst_n), .wr(wr_ctl),
        .wdata({wdata[8], wdata[7], wdata[5:4], wdata[2:0]}),
        .busy(cfg_busy), .load(cfg_load), .ldata(cfg_ldata));

    cmt_delay_write #(.W(CNT_W), .LAT(CNT_LAT)) u_dw_cnt (
        .clk(clk), .rst_n(rst_n), .wr(wr_cnt), .wdata(wdata[CNT_W-1:0]),
        .busy(cnt_busy), .load(cnt_ld), .ldata(cnt_ldata));

    cmt_delay_write #(.W(CNT_W), .LAT(CFG_LAT)) u_dw_cmp (
        .clk(clk), .rst_n(rst_n), .wr(wr_cmp), .wdata(wdata[CNT_W-1:0]),
        .busy(cmp_busy), .load(cmp_ld), .ldata(cmp_ldata));

    cmt_prescaler u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .ref_tick(ref_tick),
        .cks(cfg_q.cks), .tick(tick));

    always_comb begin
        cfg_ld   = chan_cfg_t'(cfg_ldata);
        match_ev = tick && (cnt_q == cmp_q);
        wrap_ev  = tick && !cnt_ld && (cnt_q == '1) && !(cfg_q.clr_mode && match_ev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            cmp_q   <= '1;
            cnt_q   <= '0;
            mflag_q <= 1'b0;
            ovf_q   <= 1'b0;
            dreq_q  <= 1'b0;
        end else begin
            if (cfg_load) cfg_q <= cfg_ld;
            if (cmp_ld)   cmp_q <= cmp_ldata;
            if (cnt_ld)
                cnt_q <= cnt_ldata;
            else if (tick)
                cnt_q <= (match_ev && cfg_q.clr_mode) ? '0 : cnt_q + 1'b1;
            if (match_ev)
                mflag_q <= 1'b1;
            else if (wr_ctl && !wdata[FLAG_MATCH_BIT])
                mflag_q <= 1'b0;
            if (wrap_ev)
                ovf_q <= 1'b1;
            else if (wr_ctl && !wdata[FLAG_OVF_BIT])
                ovf_q <= 1'b0;
            dreq_q <= match_ev && (cfg_q.req_sel == REQ_DMA);
        end
    end

    always_comb begin
        ctl_rd = {16'b0, mflag_q, ovf_q, cnt_busy, 4'b0, cfg_q.clr_mode,
                  cfg_q.out_en, 1'b0, cfg_q.req_sel, 1'b0, cfg_q.cks};
        irq    = mflag_q && cfg_q.out_en && (cfg_q.req_sel == REQ_IRQ);
        dreq   = dreq_q;
    end

    // R2: a stopped channel holds its count
    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_ld) |=> $stable(cnt_q));

    // R7: a matching tick in clear mode leaves the counter at zero
    a_r7_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (match_ev && cfg_q.clr_mode && !cnt_ld) |=> (cnt_q == '0));

    // R8: overflow only rises from an all-ones count
    a_r8_ovf_from_top: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> ($past(cnt_q) == '1));

    // R11: a DMA pulse follows a compare hit
    a_r11_dreq_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_q |-> $past(cnt_q == cmp_q));

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer #(
    parameter int NCH     = 4,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 12,
    parameter int CFG_LAT = 2,
    parameter int CNT_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    irq,
    output logic [NCH-1:0]    dreq
);
    localparam int SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] slot;
    logic [1:0]        regsel;
    logic              aligned;
    logic              wr_en;
    logic [NCH-1:0]    run_q;
    logic [31:0]       ctl_rd  [NCH];
    logic [31:0]       cnt_rd  [NCH];
    logic [31:0]       cmp_rd  [NCH];

    always_comb begin
        slot    = bus_addr[ADDR_W-1:4];
        regsel  = bus_addr[3:2];
        aligned = (bus_addr[1:0] == 2'b00);
        wr_en   = bus_sel && bus_we && aligned;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (wr_en && slot == '0 && regsel == 2'd0)
            run_q <= bus_wdata[NCH-1:0];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic             hit;
        logic [CNT_W-1:0] cnt_w;
        logic [CNT_W-1:0] cmp_w;

        assign hit = wr_en && (slot == SLOT_W'(i + 1));

        cmt_channel #(.CNT_W(CNT_W), .CFG_LAT(CFG_LAT), .CNT_LAT(CNT_LAT)) u_ch (
            .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run(run_q[i]),
            .wr_ctl(hit && regsel == 2'd0),
            .wr_cnt(hit && regsel == 2'd1),
            .wr_cmp(hit && regsel == 2'd2),
            .wdata(bus_wdata), .ctl_rd(ctl_rd[i]), .cnt_q(cnt_w), .cmp_q(cmp_w),
            .irq(irq[i]), .dreq(dreq[i]));

        assign cnt_rd[i] = 32'(cnt_w);
        assign cmp_rd[i] = 32'(cmp_w);
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (slot == '0 && regsel == 2'd0)
                bus_rdata = 32'(run_q);
            for (int i = 0; i < NCH; i++) begin
                if (slot == SLOT_W'(i + 1)) begin
                    case (regsel)
                        2'd0:    bus_rdata = ctl_rd[i];
                        2'd1:    bus_rdata = cnt_rd[i];
                        2'd2:    bus_rdata = cmp_rd[i];
                        default: bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    // R2: the run word takes the written value on the next cycle
    a_r2_run_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot == '0 && regsel == 2'd0) |=> (run_q == $past(bus_wdata[NCH-1:0])));

endmodule

// File: tb/cmt_timer_tb.sv
`timescale 1ns/100ps
module cmt_timer_tb;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] irq;
    logic [NCH-1:0] dreq;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 0;

    cmt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .dreq(dreq));

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [11:0] a_ctl(input int ch); return 12'(16 + 16*ch);     endfunction
    function automatic logic [11:0] a_cnt(input int ch); return 12'(16 + 16*ch + 4); endfunction
    function automatic logic [11:0] a_cmp(input int ch); return 12'(16 + 16*ch + 8); endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.1;
        v = bus_rdata;
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int k;
        int m;
        logic [31:0] held;
        int ones;
        void'($urandom(32'd20240611));

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            rd(a_ctl(c), v); check("R1 ctl", v, 32'h0);
            rd(a_cnt(c), v); check("R1 cnt", v, 32'h0);
            rd(a_cmp(c), v); check("R1 cmp", v, 32'hFFFF_FFFF);
        end
        rd(12'h000, v); check("R1 run", v, 32'h0);
        check("R1 irq/dreq", {28'b0, irq | dreq}, 32'h0);

        // R5 compare write latency
        wr(a_cmp(0), 32'd10);
        rd(a_cmp(0), v); check("R5 cmp early", v, 32'hFFFF_FFFF);
        idle(1); rd(a_cmp(0), v); check("R5 cmp early", v, 32'hFFFF_FFFF);
        idle(1); rd(a_cmp(0), v); check("R5 cmp applied", v, 32'd10);

        // R4 counter write latency and pending bit 13
        wr(a_cnt(0), 32'd100);
        rd(a_ctl(0), v); check("R4 pending", 32'(v[13]), 32'd1);
        rd(a_cnt(0), v); check("R4 old count", v, 32'd0);
        idle(2); rd(a_ctl(0), v); check("R4 pending", 32'(v[13]), 32'd1);
        idle(1); rd(a_ctl(0), v); check("R4 done", 32'(v[13]), 32'd0);
        rd(a_cnt(0), v); check("R4 loaded", v, 32'd100);

        // R2/R3 start channel 0 with divide-by-1
        ref_tick = 1'b1;
        wr(a_ctl(0), 32'h7); idle(2);
        wr(12'h000, 32'h1); k = cyc;
        wait_to(k + 5);
        rd(a_cnt(0), v); check("R3 div1 count", v, 32'd105);
        rd(a_cnt(1), v); check("R2 other channel idle", v, 32'd0);
        wr(12'h000, 32'h0); m = cyc;
        rd(a_cnt(0), held); check("R2 stop value", held, 32'(100 + m - k));
        idle(5); rd(a_cnt(0), v); check("R2 held", v, held);

        // R6/R7/R10 periodic channel 1, compare 4
        wr(a_cmp(1), 32'd4);
        wr(a_ctl(1), 32'h1A7); idle(2);
        wr(12'h000, 32'h2); k = cyc;
        wait_to(k + 4);
        rd(a_cnt(1), v); check("R7 before match", v, 32'd4);
        rd(a_ctl(1), v); check("R6 flag clear", 32'(v[15]), 32'd0);
        check("R10 irq low", 32'(irq[1]), 32'd0);
        wait_to(k + 5);
        rd(a_cnt(1), v); check("R7 restart", v, 32'd0);
        rd(a_ctl(1), v); check("R6 flag set", 32'(v[15]), 32'd1);
        check("R10 irq high", 32'(irq[1]), 32'd1);
        // R9 clear on a non-match edge
        wait_to(k + 6); wr(a_ctl(1), 32'h1A7);
        rd(a_ctl(1), v); check("R9 cleared", 32'(v[15]), 32'd0);
        check("R10 irq follows flag", 32'(irq[1]), 32'd0);
        wait_to(k + 10);
        rd(a_cnt(1), v); check("R7 period", v, 32'd0);
        rd(a_ctl(1), v); check("R6 set again", 32'(v[15]), 32'd1);
        // R9 writing 1 keeps the flag
        wait_to(k + 11); wr(a_ctl(1), 32'h81A7);
        rd(a_ctl(1), v); check("R9 write one keeps", 32'(v[15]), 32'd1);
        // R9 clear coincident with match: set wins
        wait_to(k + 14); wr(a_ctl(1), 32'h1A7);
        rd(a_ctl(1), v); check("R9 set beats clear", 32'(v[15]), 32'd1);
        wait_to(k + 16); wr(a_ctl(1), 32'h1A7);
        rd(a_ctl(1), v); check("R9 later clear", 32'(v[15]), 32'd0);
        wr(12'h000, 32'h0);

        // R8 free-running wrap on channel 2
        wr(a_cnt(2), 32'hFFFF_FFFD); idle(2);
        wr(a_ctl(2), 32'h7); idle(2);
        wr(12'h000, 32'h4); k = cyc;
        wait_to(k + 2);
        rd(a_cnt(2), v); check("R8 top", v, 32'hFFFF_FFFF);
        rd(a_ctl(2), v); check("R8 no ovf yet", 32'(v[14]), 32'd0);
        wait_to(k + 3);
        rd(a_cnt(2), v); check("R8 wrap", v, 32'd0);
        rd(a_ctl(2), v); check("R8 flags", v, 32'h0000_C007);
        wr(a_ctl(2), 32'h8007);
        rd(a_ctl(2), v); check("R9 ovf only cleared", v, 32'h0000_8007);

        // R11 DMA pulse on channel 3
        wr(a_cmp(3), 32'd2);
        wr(a_ctl(3), 32'h117); idle(2);
        wr(12'h000, 32'h8); k = cyc;
        wait_to(k + 3);
        check("R11 dreq pulse", 32'(dreq[3]), 32'd1);
        check("R11 no irq", 32'(irq[3]), 32'd0);
        wait_to(k + 4); check("R11 dreq one cycle", 32'(dreq[3]), 32'd0);
        wait_to(k + 6); check("R11 dreq next period", 32'(dreq[3]), 32'd1);
        wr(12'h000, 32'h0);

        // R3 divide by 8, 32 and disabled
        wr(a_ctl(0), 32'h4); wr(a_cnt(0), 32'd0); idle(2);
        wr(12'h000, 32'h1); k = cyc;
        wait_to(k + 7);  rd(a_cnt(0), v); check("R3 div8 before", v, 32'd0);
        wait_to(k + 8);  rd(a_cnt(0), v); check("R3 div8 tick", v, 32'd1);
        wait_to(k + 16); rd(a_cnt(0), v); check("R3 div8 second", v, 32'd2);
        wr(12'h000, 32'h0);
        wr(a_ctl(0), 32'h5); wr(a_cnt(0), 32'd0); idle(2);
        wr(12'h000, 32'h1); k = cyc;
        wait_to(k + 31); rd(a_cnt(0), v); check("R3 div32 before", v, 32'd0);
        wait_to(k + 32); rd(a_cnt(0), v); check("R3 div32 tick", v, 32'd1);
        wr(12'h000, 32'h0);
        wr(a_ctl(0), 32'h0); wr(a_cnt(0), 32'd0); idle(2);
        wr(12'h000, 32'h1); idle(20);
        rd(a_cnt(0), v); check("R3 code 0 idle", v, 32'd0);
        wr(12'h000, 32'h0);

        // R3 random reference pulses: divide by 1 and 8 side by side
        wr(a_ctl(0), 32'h7); wr(a_ctl(1), 32'h4);
        wr(a_cnt(0), 32'd0); wr(a_cnt(1), 32'd0); idle(3);
        ref_tick = 1'b0;
        wr(12'h000, 32'h3);
        ones = 0;
        for (int r = 0; r < 8; r++) begin
            int len;
            len = 20 + int'($urandom % 40);
            for (int j = 0; j < len; j++) begin
                ref_tick = 1'($urandom % 2);
                ones += int'(ref_tick);
                @(negedge clk);
            end
            ref_tick = 1'b0;
            rd(a_cnt(0), v); check("R3 random div1", v, 32'(ones));
            rd(a_cnt(1), v); check("R3 random div8", v, 32'(ones / 8));
        end

        // R12 map and unused bits
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, v); check("R12 run width", v, 32'hF);
        rd(12'h01C, v); check("R12 unmapped", v, 32'h0);
        rd(12'h004, v); check("R12 unmapped global", v, 32'h0);

        done = 1;
        summary();
        $finish;
    end
endmodule